// File: doc/BRIEF.md
# Auto-Indexed Power Setting Table

This block holds a small table of power amplifier settings: eight entries of eight bits each. A serial front end fills and reads the table without sending an address. Each byte access uses the entry pointed to by an internal index counter and then moves the counter on by one. The counter wraps from the last entry back to entry 0. It goes back to 0 whenever chip select is inactive, so every new transaction starts at the lowest entry.

A separate 3-bit selector picks the entry that currently drives the amplifier. That selected setting is combinational from the stored table, and serial traffic never blocks it. When the sleep indication is raised, every entry is cleared to 0x00 and the counter returns to 0.

The write side is a byte stream with a valid qualifier only. The block never applies back-pressure: a byte offered while chip select is low and sleep is low is taken in the same cycle. A read request is taken under the same conditions. Its byte comes back one cycle later, qualified by a single-cycle response valid. The consumer must accept the response in that cycle, because it is not held. A write and a read offered together count as a single write access.

Top module: `pa_level_table`

## Requirements
- R1: After reset, every entry reads as 0x00, the index counter is 0 and `rd_resp_valid` is low.
- R2: A write byte taken while `cs_n` is low and `sleep` is low is stored at the entry the index counter points to, and the counter then advances by one.
- R3: A read request taken while `cs_n` is low, `sleep` is low and `wr_valid` is low returns the entry at the index counter. The data appears on `rd_data`, with `rd_resp_valid` high for exactly one cycle, in the cycle after the request. The counter then advances by one.
- R4: An access taken at index 7 moves the counter to index 0, so the ninth access of a transaction uses entry 0 again.
- R5: While `cs_n` is high the index counter is held at 0, and write or read strobes are ignored: no entry changes and no response is produced.
- R6: While `sleep` is high every entry is cleared to 0x00, the index counter is held at 0, and strobes are ignored.
- R7: `pa_setting` equals the entry numbered by `pwr_sel` in the same cycle. It changes only when `pwr_sel` changes or when that entry is written or cleared, and serial reads never disturb it.
- R8: When `wr_valid` and `rd_valid` are high in the same taken cycle, only the write happens: no read response follows, and the counter advances by one, not two.
- R9: When `sleep` and a write strobe arrive in the same cycle, the clear wins and the addressed entry holds 0x00 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select level, active low; high resets the index counter |
| sleep | input | 1 | Sleep indication; high clears the table |
| wr_valid | input | 1 | Write byte valid, taken in the same cycle (no ready) |
| wr_data | input | 8 | Write byte |
| rd_valid | input | 1 | Read request for the entry at the index counter |
| pwr_sel | input | 3 | Selector for the entry driving the amplifier |
| rd_data | output | 8 | Read response byte |
| rd_resp_valid | output | 1 | One-cycle qualifier for `rd_data` |
| pa_setting | output | 8 | Entry selected by `pwr_sel` |

## Verification
Three pairs of events can fall in the same cycle. A write and a read strobe can be raised together. A write strobe can be raised in the cycle sleep rises. A write can land on the entry that the selector is already showing. The bench raises each pair on one falling edge. For a simultaneous write and read, it checks that no response follows and that a later read returns the next entry, which shows the counter stepped only once. For a write during sleep, it checks that the selected output reads zero afterwards. For a write to the selected entry, it watches the amplifier output change in the cycle after the write edge, and only for that entry.

// File: rtl/pa_table_pkg.sv
package pa_table_pkg;
  localparam int PT_ENTRIES = 8;
  localparam int PT_WIDTH   = 8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e pick_access(input logic active,
                                            input logic wv,
                                            input logic rv);
    if (!active)  return ACC_NONE;
    else if (wv)  return ACC_WRITE;
    else if (rv)  return ACC_READ;
    else          return ACC_NONE;
  endfunction
endpackage

// File: rtl/pa_index_counter.sv
module pa_index_counter #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx <= '0;
    else if (clr)       idx <= '0;
    else if (step) begin
      if (idx == LAST)  idx <= '0;
      else              idx <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/pa_entry_store.sv
module pa_entry_store #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wipe,
  input  logic                           we,
  input  logic [IDX_W-1:0]               widx,
  input  logic [WIDTH-1:0]               wdata,
  output logic [ENTRIES-1:0][WIDTH-1:0]  entries
);
  logic [ENTRIES-1:0] hit;

  always_comb begin
    hit = '0;
    hit[widx] = we;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       entries[e] <= '0;
      else if (wipe)    entries[e] <= '0;
      else if (hit[e])  entries[e] <= wdata;
    end
  end
endmodule

// File: rtl/pa_read_port.sv
module pa_read_port #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           take,
  input  logic [IDX_W-1:0]               ridx,
  input  logic [ENTRIES-1:0][WIDTH-1:0]  entries,
  output logic [WIDTH-1:0]               rdata,
  output logic                           rvalid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= take;
      if (take) rdata <= entries[ridx];
    end
  end
endmodule

// File: rtl/pa_level_table.sv
module pa_level_table
  import pa_table_pkg::*;
#(
  parameter int ENTRIES = PT_ENTRIES,
  parameter int WIDTH   = PT_WIDTH,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sleep,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_valid,
  input  logic [IDX_W-1:0] pwr_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_resp_valid,
  output logic [WIDTH-1:0] pa_setting
);
  acc_kind_e                     acc;
  logic [IDX_W-1:0]              cur_idx;
  logic [ENTRIES-1:0][WIDTH-1:0] table_q;

  always_comb acc = pick_access(!cs_n && !sleep, wr_valid, rd_valid);

  pa_index_counter #(.ENTRIES(ENTRIES)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cs_n | sleep),
    .step  (acc != ACC_NONE),
    .idx   (cur_idx)
  );

  pa_entry_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (sleep),
    .we      (acc == ACC_WRITE),
    .widx    (cur_idx),
    .wdata   (wr_data),
    .entries (table_q)
  );

  pa_read_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (acc == ACC_READ),
    .ridx    (cur_idx),
    .entries (table_q),
    .rdata   (rd_data),
    .rvalid  (rd_resp_valid)
  );

  assign pa_setting = table_q[pwr_sel];
endmodule

// File: rtl/pa_level_table_chk.sv
module pa_level_table_chk #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sleep,
  input logic             wr_valid,
  input logic             rd_valid,
  input logic [IDX_W-1:0] pwr_sel,
  input logic             rd_resp_valid,
  input logic [WIDTH-1:0] pa_setting,
  input logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  logic live;
  assign live = !cs_n && !sleep && (wr_valid || rd_valid);

  a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sleep && rd_valid && !wr_valid) |=> rd_resp_valid);
  a_r8_write_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !rd_resp_valid);
  a_r5_idx_home: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (idx == '0));
  a_r5_no_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !rd_resp_valid);
  a_r6_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (pa_setting == '0));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (live && idx == LAST) |=> (idx == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (live && idx != LAST) |=> (idx == $past(idx) + IDX_W'(1)));
  a_r7_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !sleep) ##1 $stable(pwr_sel) |-> $stable(pa_setting));
endmodule

bind pa_level_table pa_level_table_chk #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_n          (cs_n),
  .sleep         (sleep),
  .wr_valid      (wr_valid),
  .rd_valid      (rd_valid),
  .pwr_sel       (pwr_sel),
  .rd_resp_valid (rd_resp_valid),
  .pa_setting    (pa_setting),
  .idx           (cur_idx)
);

// File: tb/pa_level_table_bench.sv
module pa_level_table_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sleep = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_valid = 1'b0;
  logic [2:0] pwr_sel = '0;
  logic [7:0] rd_data;
  logic       rd_resp_valid;
  logic [7:0] pa_setting;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  pa_level_table u_pa_level_table (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sleep(sleep),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid),
    .pwr_sel(pwr_sel), .rd_data(rd_data), .rd_resp_valid(rd_resp_valid),
    .pa_setting(pa_setting)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_byte(input string req, input logic [7:0] exp);
    @(negedge clk);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk({req, " resp valid"}, {7'd0, rd_resp_valid}, 8'd1);
    chk({req, " data"}, rd_data, exp);
  endtask

  task automatic new_txn();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < 8; i++) begin
      pwr_sel = 3'(i); #1;
      chk(req, pa_setting, model[i]);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    chk("R1 no resp", {7'd0, rd_resp_valid}, 8'd0);
    check_table("R1 entries zero");
  endtask

  task automatic t_fill_and_read();
    new_txn();
    for (int i = 0; i < 8; i++) begin
      write_byte(8'hA0 + 8'(i));
      model[i] = 8'hA0 + 8'(i);
    end
    check_table("R2 stored in order");
    new_txn();
    for (int i = 0; i < 8; i++) read_byte("R3 read in order", model[i]);
    read_byte("R4 wrap to entry 0", model[0]);
    write_byte(8'h3C);
    model[1] = 8'h3C;
    check_table("R4 write after wrap lands at 1");
  endtask

  task automatic t_cs_reset();
    new_txn();
    write_byte(8'h11); model[0] = 8'h11;
    write_byte(8'h22); model[1] = 8'h22;
    write_byte(8'h33); model[2] = 8'h33;
    @(negedge clk); cs_n = 1'b1;
    wr_valid = 1'b1; wr_data = 8'hEE;
    @(negedge clk); wr_valid = 1'b0;
    rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
    chk("R5 no resp with cs high", {7'd0, rd_resp_valid}, 8'd0);
    check_table("R5 strobe ignored with cs high");
    @(negedge clk); cs_n = 1'b0;
    write_byte(8'h44); model[0] = 8'h44;
    check_table("R5 index restarts at 0");
  endtask

  task automatic t_both_strobes();
    new_txn();
    @(negedge clk);
    wr_valid = 1'b1; rd_valid = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    model[0] = 8'h5A;
    chk("R8 no read response", {7'd0, rd_resp_valid}, 8'd0);
    check_table("R8 write taken");
    read_byte("R8 single step", model[1]);
  endtask

  task automatic t_select_live();
    new_txn();
    pwr_sel = 3'd0; #1;
    chk("R7 select 0", pa_setting, model[0]);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h9D;
    #1 chk("R7 before write edge", pa_setting, model[0]);
    @(negedge clk);
    wr_valid = 1'b0; model[0] = 8'h9D;
    chk("R7 after write edge", pa_setting, 8'h9D);
    pwr_sel = 3'd5;
    read_byte("R7 read entry 1", model[1]);
    chk("R7 unaffected by read", pa_setting, model[5]);
  endtask

  task automatic t_sleep();
    new_txn();
    @(negedge clk);
    sleep = 1'b1; wr_valid = 1'b1; wr_data = 8'hC3;
    @(negedge clk);
    wr_valid = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    check_table("R9 R6 cleared despite write");
    @(negedge clk); sleep = 1'b0;
    read_byte("R6 index 0 after sleep", 8'h00);
    write_byte(8'h77); model[1] = 8'h77;
    check_table("R6 writes resume");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_and_read();
    t_cs_reset();
    t_both_strobes();
    t_select_live();
    t_sleep();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule